// File: doc/BRIEF.md
# BCD Time-of-Day and Calendar Core with Freezable Host View

This core keeps the time of day and the calendar date in packed BCD. It advances on a one-cycle tick that arrives every hundredth of a second. Two sets of time registers are kept. The running set counts whenever the oscillator bit allows it. The host set is what the byte-wide register port returns, and it is refreshed from the running set on each tick.

A host that wants a consistent multi-byte snapshot clears the transfer-enable bit in the command byte. The host set then stays fixed while the running set keeps counting. Setting the bit again brings the host set back in step on the next tick, so no time is lost. Bytes written while the host set is frozen are first held in the host set. They are pushed into the running set at the moment transfers are re-enabled.

The seconds-to-year part of the running set moves one tick early, on the tick that takes hundredths to 99. The host set only sees that change on the tick that wraps hundredths to 00. Hours may be kept in 24-hour form or in 12-hour form with a PM flag. Month lengths follow the calendar, and February gains a day in years divisible by four. The month byte also carries an oscillator-stop bit and an active-low enable for a 1024 Hz square wave.

Top module: `bcd_calendar_core`

## Requirements
- R1: Byte addresses are 0x0 hundredths, 0x1 seconds, 0x2 minutes, 0x4 hours, 0x6 day of week, 0x8 date, 0x9 month, 0xA year and 0xB command. After reset the core reads 00:00:00.00 in 24-hour form, with day 1, date 01, month 01 and year 00. Command reads 0x80 (transfer enabled), and month reads 0xC1 (oscillator stopped, square wave off).
- R2: While command bit 7 is 1 and the oscillator runs, every tick refreshes the host hundredths byte with the new running value, and the other host bytes follow the running set.
- R3: Month bit 7 set to 1 stops the oscillator. Ticks then change no time byte.
- R4: Command bit 7 written 0 freezes every host time byte while ticks keep advancing the running set. After bit 7 is written back to 1, the first tick shows the running time with every elapsed tick counted.
- R5: On the tick that takes hundredths from 98 to 99, the host seconds-to-year bytes keep their old values. They take the advanced values on the tick that takes hundredths from 99 to 00.
- R6: With hours bit 6 = 0, hours count 00 to 23 in BCD (bits 5:4 tens, bits 3:0 units), and 23 wraps to 00 with a carry into the date.
- R7: With hours bit 6 = 1, bits 4:0 hold 01 to 12 in BCD and bit 5 is PM. The count runs 12, 01 … 11. The PM flag flips on 11 to 12, and the change from 11 PM to 12 AM carries into the date.
- R8: The date wraps to 01 after 28 or 29 in February (29 when the BCD year is divisible by 4), after 30 in April, June, September and November, and after 31 in the other months.
- R9: Day of week counts 1 to 7 and wraps to 1 on each date carry. Month 12 wraps to 01 and increments the year, and year 99 wraps to 00.
- R10: Bits that are not used read 0 whatever was written: bit 7 of seconds, minutes and hours; bits 7:3 of day; bits 7:6 of date; bit 5 of month; bits 6:0 of command. Addresses 0x3, 0x5, 0x7 and 0xC–0xF read 0x00.
- R11: sqw_en_o is 1 exactly when month bit 6 is 0.
- R12: A time byte written with transfers enabled takes effect in both sets at once. Written while frozen, it reads back at once and enters the running set on the command write that sets bit 7 again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle pulse every hundredth of a second |
| host_we_i | input | 1 | Byte write strobe, one cycle per write |
| host_addr_i | input | ADDR_W | Register byte address |
| host_wdata_i | input | 8 | Write data |
| host_rdata_o | output | 8 | Read data for host_addr_i, combinational from the host set |
| sqw_en_o | output | 1 | Enable for the 1024 Hz square-wave output |

## Verification
The bench drives the rollovers where a carry chain goes wrong: 11 AM to 12 PM, 11 PM to 12 AM, 12 to 01, the leap-year Feb 29, Feb 28 in a common year, a 30-day month end, Dec 31 of year 99, and day 7 back to 1. A core with an off-by-one month table, a bad leap test or a swapped PM toggle would show the wrong date or hour on the byte read after the wrap. Each of these cases also reads the host bytes on the 99-hundredths tick. A core that exposed its early upper-field advance would show the new second one tick too soon there. The freeze sequence checks two things: that 250 ticks leave the host bytes unchanged, and that the time after re-enable includes every tick and any byte written while frozen. A core that paused its running set, or that dropped the pending write, would resume with the wrong time.

// File: rtl/cal_pkg.sv
package cal_pkg;

  localparam int NF = 8;

  localparam int F_HUND = 0;
  localparam int F_SEC  = 1;
  localparam int F_MIN  = 2;
  localparam int F_HOUR = 3;
  localparam int F_DAY  = 4;
  localparam int F_DATE = 5;
  localparam int F_MON  = 6;
  localparam int F_YEAR = 7;

  localparam logic [3:0] ADDR_CMD = 4'hB;

  typedef logic [NF-1:0][7:0] fields_t;

  function automatic logic [3:0] field_addr(input int idx);
    case (idx)
      F_HUND:  return 4'h0;
      F_SEC:   return 4'h1;
      F_MIN:   return 4'h2;
      F_HOUR:  return 4'h4;
      F_DAY:   return 4'h6;
      F_DATE:  return 4'h8;
      F_MON:   return 4'h9;
      default: return 4'hA;
    endcase
  endfunction

  // bits of each field that are stored; the rest read 0
  function automatic logic [7:0] field_mask(input int idx);
    case (idx)
      F_HUND:  return 8'hFF;
      F_SEC:   return 8'h7F;
      F_MIN:   return 8'h7F;
      F_HOUR:  return 8'h7F;
      F_DAY:   return 8'h07;
      F_DATE:  return 8'h3F;
      F_MON:   return 8'h1F;
      default: return 8'hFF;
    endcase
  endfunction

  function automatic logic [7:0] field_rst(input int idx);
    case (idx)
      F_DAY, F_DATE, F_MON: return 8'h01;
      default:              return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'h0};
    return v + 8'd1;
  endfunction

  function automatic logic [6:0] bcd_to_bin(input logic [7:0] v);
    logic [6:0] t;
    t = {3'b000, v[7:4]};
    return (t << 3) + (t << 1) + {3'b000, v[3:0]};
  endfunction

endpackage

// File: rtl/cal_hour_step.sv
module cal_hour_step
  import cal_pkg::*;
(
  input  logic [7:0] hour_i,
  input  logic       en_i,
  output logic [7:0] hour_o,
  output logic       carry_o
);

  logic       mode12;
  logic       pm;
  logic [4:0] h12;
  logic [7:0] inc24;
  logic [7:0] inc12;

  assign mode12 = hour_i[6];
  assign pm     = hour_i[5];
  assign h12    = hour_i[4:0];
  assign inc24  = bcd_inc({2'b00, hour_i[5:0]});
  assign inc12  = bcd_inc({3'b000, h12});

  always_comb begin
    hour_o  = hour_i;
    carry_o = 1'b0;
    if (en_i) begin
      if (!mode12) begin
        if (hour_i[5:0] == 6'h23) begin
          hour_o  = 8'h00;
          carry_o = 1'b1;
        end else begin
          hour_o = {2'b00, inc24[5:0]};
        end
      end else begin
        if (h12 == 5'h11) begin
          hour_o  = {2'b01, ~pm, 5'h12};
          carry_o = pm;
        end else if (h12 == 5'h12) begin
          hour_o = {2'b01, pm, 5'h01};
        end else begin
          hour_o = {2'b01, pm, inc12[4:0]};
        end
      end
    end
  end

endmodule

// File: rtl/cal_date_step.sv
module cal_date_step
  import cal_pkg::*;
(
  input  logic [7:0] date_i,
  input  logic [7:0] mon_i,
  input  logic [7:0] year_i,
  input  logic       en_i,
  output logic [7:0] date_o,
  output logic [7:0] mon_o,
  output logic [7:0] year_o
);

  logic [6:0] year_bin;
  logic       leap;
  logic [7:0] last_day;

  assign year_bin = bcd_to_bin(year_i);
  assign leap     = (year_bin[1:0] == 2'b00);

  always_comb begin
    case (mon_i)
      8'h02:                      last_day = leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: last_day = 8'h30;
      default:                    last_day = 8'h31;
    endcase
  end

  always_comb begin
    date_o = date_i;
    mon_o  = mon_i;
    year_o = year_i;
    if (en_i) begin
      if (date_i >= last_day) begin
        date_o = 8'h01;
        if (mon_i >= 8'h12) begin
          mon_o  = 8'h01;
          year_o = (year_i >= 8'h99) ? 8'h00 : bcd_inc(year_i);
        end else begin
          mon_o = bcd_inc(mon_i);
        end
      end else begin
        date_o = bcd_inc(date_i);
      end
    end
  end

endmodule

// File: rtl/cal_time_advance.sv
// One-second advance of seconds through year; hundredths passes through.
module cal_time_advance
  import cal_pkg::*;
(
  input  fields_t cur_i,
  output fields_t nxt_o
);

  logic       min_en;
  logic       hour_en;
  logic       day_carry;
  logic [7:0] hour_n;
  logic [7:0] date_n;
  logic [7:0] mon_n;
  logic [7:0] year_n;

  assign min_en  = (cur_i[F_SEC] >= 8'h59);
  assign hour_en = min_en && (cur_i[F_MIN] >= 8'h59);

  cal_hour_step i_hour (
    .hour_i  (cur_i[F_HOUR]),
    .en_i    (hour_en),
    .hour_o  (hour_n),
    .carry_o (day_carry)
  );

  cal_date_step i_date (
    .date_i (cur_i[F_DATE]),
    .mon_i  (cur_i[F_MON]),
    .year_i (cur_i[F_YEAR]),
    .en_i   (day_carry),
    .date_o (date_n),
    .mon_o  (mon_n),
    .year_o (year_n)
  );

  always_comb begin
    nxt_o         = cur_i;
    nxt_o[F_SEC]  = min_en ? 8'h00 : bcd_inc(cur_i[F_SEC]);
    if (min_en)
      nxt_o[F_MIN] = hour_en ? 8'h00 : bcd_inc(cur_i[F_MIN]);
    nxt_o[F_HOUR] = hour_n;
    if (day_carry)
      nxt_o[F_DAY] = (cur_i[F_DAY] >= 8'h07) ? 8'h01 : bcd_inc(cur_i[F_DAY]);
    nxt_o[F_DATE] = date_n;
    nxt_o[F_MON]  = mon_n;
    nxt_o[F_YEAR] = year_n;
  end

endmodule

// File: rtl/cal_read_mux.sv
module cal_read_mux
  import cal_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  fields_t           vis_i,
  input  logic              te_i,
  input  logic              osc_n_i,
  input  logic              sqw_n_i,
  output logic [7:0]        rdata_o
);

  localparam logic [ADDR_W-1:0] A_CMD = ADDR_W'(ADDR_CMD);
  localparam logic [ADDR_W-1:0] A_MON = ADDR_W'(field_addr(F_MON));

  always_comb begin
    rdata_o = 8'h00;
    for (int i = 0; i < NF; i++) begin
      if (addr_i == ADDR_W'(field_addr(i))) rdata_o = vis_i[i];
    end
    if (addr_i == A_MON) rdata_o[7:6] = {osc_n_i, sqw_n_i};
    if (addr_i == A_CMD) rdata_o = {te_i, 7'b0};
  end

endmodule

// File: rtl/bcd_calendar_core.sv
module bcd_calendar_core
  import cal_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              host_we_i,
  input  logic [ADDR_W-1:0] host_addr_i,
  input  logic [7:0]        host_wdata_i,
  output logic [7:0]        host_rdata_o,
  output logic              sqw_en_o
);

  localparam logic [ADDR_W-1:0] A_CMD = ADDR_W'(ADDR_CMD);
  localparam logic [ADDR_W-1:0] A_MON = ADDR_W'(field_addr(F_MON));

  fields_t         int_f, int_d;    // running set
  fields_t         vis_f, vis_d;    // host set
  fields_t         adv_f, run_f, xfer_f;
  logic [NF-1:0]   dirty_q, dirty_d;
  logic [NF-1:0]   wr_hit, xfer_ok;
  logic            te_q, osc_n_q, sqw_n_q;
  logic            run, cmd_wr, mon_wr, te_load;
  logic            hund_at_98, hund_wrap;
  logic [7:0]      hund_next;

  assign run        = tick_i & ~osc_n_q;
  assign cmd_wr     = host_we_i && (host_addr_i == A_CMD);
  assign mon_wr     = host_we_i && (host_addr_i == A_MON);
  assign te_load    = cmd_wr & host_wdata_i[7] & ~te_q;
  assign hund_at_98 = (int_f[F_HUND] == 8'h98);
  assign hund_wrap  = (int_f[F_HUND] >= 8'h99);
  assign hund_next  = hund_wrap ? 8'h00 : bcd_inc(int_f[F_HUND]);

  cal_time_advance i_adv (
    .cur_i (int_f),
    .nxt_o (adv_f)
  );

  // upper fields advance one tick early, host copy waits for the 99->00 wrap
  always_comb begin
    run_f          = hund_at_98 ? adv_f : int_f;
    run_f[F_HUND]  = hund_next;
    xfer_f         = int_f;
    xfer_f[F_HUND] = hund_next;
    xfer_ok        = {NF{hund_next != 8'h99}};
    xfer_ok[F_HUND] = 1'b1;
  end

  always_comb begin
    int_d   = int_f;
    vis_d   = vis_f;
    dirty_d = dirty_q;
    for (int i = 0; i < NF; i++) begin
      wr_hit[i] = host_we_i && (host_addr_i == ADDR_W'(field_addr(i)));
      if (wr_hit[i] && te_q)          int_d[i] = host_wdata_i & field_mask(i);
      else if (te_load && dirty_q[i]) int_d[i] = vis_f[i];
      else if (run)                   int_d[i] = run_f[i];

      if (wr_hit[i])                       vis_d[i] = host_wdata_i & field_mask(i);
      else if (te_q && run && xfer_ok[i])  vis_d[i] = xfer_f[i];

      if (wr_hit[i] && !te_q) dirty_d[i] = 1'b1;
      else if (te_load)       dirty_d[i] = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NF; i++) begin
        int_f[i] <= field_rst(i);
        vis_f[i] <= field_rst(i);
      end
      dirty_q <= '0;
      te_q    <= 1'b1;
      osc_n_q <= 1'b1;
      sqw_n_q <= 1'b1;
    end else begin
      int_f   <= int_d;
      vis_f   <= vis_d;
      dirty_q <= dirty_d;
      if (cmd_wr) te_q <= host_wdata_i[7];
      if (mon_wr) begin
        osc_n_q <= host_wdata_i[7];
        sqw_n_q <= host_wdata_i[6];
      end
    end
  end

  cal_read_mux #(
    .ADDR_W (ADDR_W)
  ) i_rmux (
    .addr_i  (host_addr_i),
    .vis_i   (vis_f),
    .te_i    (te_q),
    .osc_n_i (osc_n_q),
    .sqw_n_i (sqw_n_q),
    .rdata_o (host_rdata_o)
  );

  assign sqw_en_o = ~sqw_n_q;

endmodule

// File: rtl/cal_core_checks.sv
module cal_core_checks
  import cal_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tick_i,
  input logic              host_we_i,
  input logic [ADDR_W-1:0] host_addr_i,
  input logic [7:0]        host_rdata_o,
  input logic              te_q,
  input logic              osc_n_q,
  input fields_t           int_f,
  input fields_t           vis_f
);

  assert_xfer_hund_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (te_q && tick_i && !osc_n_q && !host_we_i) |=> (vis_f[F_HUND] == int_f[F_HUND]));

  assert_osc_stop_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (osc_n_q && !host_we_i) |=> $stable(int_f));

  assert_frozen_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!te_q && !host_we_i) |=> $stable(vis_f));

  assert_early_run_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !osc_n_q && !host_we_i && int_f[F_HUND] == 8'h98)
      |=> (int_f[F_SEC] != $past(int_f[F_SEC])));

  assert_late_host_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !osc_n_q && !host_we_i && int_f[F_HUND] == 8'h98)
      |=> $stable(vis_f[F_SEC]));

  assert_sec_unused_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_addr_i == ADDR_W'(4'h1)) |-> (host_rdata_o[7] == 1'b0));

  assert_day_unused_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_addr_i == ADDR_W'(4'h6)) |-> (host_rdata_o[7:3] == 5'b0));

endmodule

bind bcd_calendar_core cal_core_checks #(
  .ADDR_W (ADDR_W)
) i_checks (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .tick_i       (tick_i),
  .host_we_i    (host_we_i),
  .host_addr_i  (host_addr_i),
  .host_rdata_o (host_rdata_o),
  .te_q         (te_q),
  .osc_n_q      (osc_n_q),
  .int_f        (int_f),
  .vis_f        (vis_f)
);

// File: tb/test_bcd_calendar_core.sv
module test_bcd_calendar_core;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       we = 1'b0;
  logic [3:0] addr = 4'h0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       sqw_en;

  int total = 0;
  int bad   = 0;

  always #4 clk = ~clk;

  bcd_calendar_core #(.ADDR_W(4)) i_bcd_calendar_core (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .tick_i       (tick),
    .host_we_i    (we),
    .host_addr_i  (addr),
    .host_wdata_i (wdata),
    .host_rdata_o (rdata),
    .sqw_en_o     (sqw_en)
  );

  // reference time kept as plain integers
  int m_hund, m_sec, m_min, m_hr, m_day, m_date, m_mon, m_year;
  bit m_12, m_osc_n, m_sqw_n, m_te;

  function automatic logic [7:0] to_bcd(input int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction

  function automatic int dim(input int mon, input int yr);
    if (mon == 2) return (yr % 4 == 0) ? 29 : 28;
    if (mon == 4 || mon == 6 || mon == 9 || mon == 11) return 30;
    return 31;
  endfunction

  function automatic logic [7:0] hour_reg();
    int h;
    logic [7:0] b;
    if (!m_12) return to_bcd(m_hr);
    h = m_hr % 12;
    if (h == 0) h = 12;
    b = to_bcd(h);
    return {2'b01, (m_hr >= 12), b[4:0]};
  endfunction

  function automatic logic [7:0] exp_reg(input int a);
    logic [7:0] b;
    case (a)
      0:  return to_bcd(m_hund);
      1:  return to_bcd(m_sec);
      2:  return to_bcd(m_min);
      4:  return hour_reg();
      6:  return to_bcd(m_day);
      8:  return to_bcd(m_date);
      9:  begin b = to_bcd(m_mon); return {m_osc_n, m_sqw_n, 1'b0, b[4:0]}; end
      10: return to_bcd(m_year);
      11: return {m_te, 7'b0};
      default: return 8'h00;
    endcase
  endfunction

  task automatic model_tick();
    m_hund++;
    if (m_hund == 100) begin
      m_hund = 0; m_sec++;
      if (m_sec == 60) begin
        m_sec = 0; m_min++;
        if (m_min == 60) begin
          m_min = 0; m_hr++;
          if (m_hr == 24) begin
            m_hr = 0;
            m_day = (m_day == 7) ? 1 : m_day + 1;
            m_date++;
            if (m_date > dim(m_mon, m_year)) begin
              m_date = 1; m_mon++;
              if (m_mon == 13) begin
                m_mon = 1;
                m_year = (m_year + 1) % 100;
              end
            end
          end
        end
      end
    end
  endtask

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [7:0] d);
    @(negedge clk);
    we = 1'b1; addr = 4'(a); wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input int a, output logic [7:0] v);
    @(negedge clk);
    addr = 4'(a);
    #1;
    v = rdata;
  endtask

  task automatic chk_reg(input string tag, input int a);
    logic [7:0] v;
    rd(a, v);
    check($sformatf("%s addr %0h", tag, a), v, exp_reg(a));
  endtask

  task automatic chk_all(input string tag);
    int al[8] = '{0, 1, 2, 4, 6, 8, 9, 10};
    foreach (al[k]) chk_reg(tag, al[k]);
  endtask

  task automatic do_tick(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
      if (!m_osc_n) model_tick();
    end
  endtask

  task automatic set_time(input bit md12, input int hr, input int mn, input int sc,
                          input int hd, input int dy, input int dt, input int mo, input int yr);
    logic [7:0] mb;
    mb = to_bcd(mo);
    m_osc_n = 1'b1; m_mon = mo;
    wr(9, {1'b1, m_sqw_n, 1'b0, mb[4:0]});
    m_hund = hd; m_sec = sc; m_min = mn; m_hr = hr; m_12 = md12;
    m_day = dy; m_date = dt; m_year = yr;
    wr(0, to_bcd(hd));
    wr(1, to_bcd(sc));
    wr(2, to_bcd(mn));
    wr(4, hour_reg());
    wr(6, to_bcd(dy));
    wr(8, to_bcd(dt));
    wr(10, to_bcd(yr));
    m_osc_n = 1'b0;
    wr(9, {1'b0, m_sqw_n, 1'b0, mb[4:0]});
  endtask

  task automatic run_case(input string tag, input bit md12, input int hr, input int dy,
                          input int dt, input int mo, input int yr);
    set_time(md12, hr, 59, 59, 98, dy, dt, mo, yr);
    do_tick(1);
    chk_all({tag, " R5 at 99"});
    do_tick(1);
    chk_all(tag);
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: run did not finish, got timeout expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    logic [7:0] v;
    logic [7:0] snap [16];
    void'($urandom(32'd1386));

    m_hund = 0; m_sec = 0; m_min = 0; m_hr = 0; m_12 = 0;
    m_day = 1; m_date = 1; m_mon = 1; m_year = 0;
    m_osc_n = 1; m_sqw_n = 1; m_te = 1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk_all("R1 reset");
    chk_reg("R1 reset command", 11);
    check("R11 reset sqw", {7'b0, sqw_en}, 8'h00);

    // R3 ticks ignored while stopped
    do_tick(5);
    chk_reg("R3 osc stopped", 0);

    // R10 unused bits
    wr(1, 8'hD9); rd(1, v); check("R10 seconds bit7", v, 8'h59);
    wr(4, 8'h92); rd(4, v); check("R10 hours bit7", v, 8'h12);
    wr(6, 8'hFE); rd(6, v); check("R10 day bits", v, 8'h06);
    wr(8, 8'hE5); rd(8, v); check("R10 date bits", v, 8'h25);
    wr(9, 8'hBF); rd(9, v); check("R10 month bit5", v, 8'h9F);
    check("R11 sqw on", {7'b0, sqw_en}, 8'h01);
    wr(11, 8'hFF); rd(11, v); check("R10 command bits", v, 8'h80);
    wr(3, 8'h55); rd(3, v); check("R10 alarm slot", v, 8'h00);
    wr(12, 8'h12); rd(12, v); check("R10 high slot", v, 8'h00);
    wr(9, 8'hC1); m_sqw_n = 1;
    check("R11 sqw off", {7'b0, sqw_en}, 8'h00);

    // calendar corners
    run_case("R6 R8 R9 leap feb", 1'b0, 23, 7, 28, 2, 24);
    run_case("R8 common feb", 1'b0, 23, 3, 28, 2, 23);
    run_case("R8 year00 feb", 1'b0, 23, 2, 28, 2, 0);
    run_case("R9 year wrap", 1'b0, 23, 5, 31, 12, 99);
    run_case("R8 april end", 1'b0, 23, 1, 30, 4, 10);
    run_case("R7 11am to 12pm", 1'b1, 11, 2, 15, 1, 30);
    run_case("R7 11pm to 12am", 1'b1, 23, 3, 15, 1, 30);
    run_case("R7 12pm to 1pm", 1'b1, 12, 4, 15, 1, 30);
    run_case("R7 12am to 1am", 1'b1, 0, 4, 15, 1, 30);
    run_case("R6 mid hour", 1'b0, 9, 4, 15, 7, 45);

    // R4 freeze, R12 frozen write
    set_time(1'b0, 10, 20, 30, 40, 2, 5, 6, 21);
    do_tick(1);
    for (int a = 0; a < 16; a++) snap[a] = exp_reg(a);
    wr(11, 8'h00); m_te = 0;
    do_tick(250);
    for (int a = 0; a < 11; a++) begin
      if (a != 3 && a != 5 && a != 7) begin
        rd(a, v);
        check($sformatf("R4 frozen addr %0h", a), v, snap[a]);
      end
    end
    wr(1, 8'h45);
    rd(1, v); check("R12 frozen write readback", v, 8'h45);
    do_tick(3);
    wr(11, 8'h80); m_te = 1; m_sec = 45;
    do_tick(1);
    chk_all("R4 R12 resume");
    wr(2, to_bcd(33)); m_min = 33;
    chk_reg("R12 live write", 2);
    do_tick(2);
    chk_all("R12 live write runs");

    // constrained random times and run lengths
    for (int r = 0; r < 25; r++) begin
      int mo, yr, dt;
      mo = 1 + $urandom_range(0, 11);
      yr = $urandom_range(0, 99);
      dt = 1 + $urandom_range(0, dim(mo, yr) - 1);
      set_time(1'($urandom_range(0, 1)), $urandom_range(0, 23), $urandom_range(0, 59),
               $urandom_range(0, 59), $urandom_range(0, 99), 1 + $urandom_range(0, 6),
               dt, mo, yr);
      do_tick($urandom_range(0, 500));
      chk_all("R2 random run");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule